// File: doc/BRIEF.md
# Two-Wire Memory Slave Interface

This block is the slave end of a two-wire serial bus, placed in front of a 2048-byte memory. It brings the bus clock and data lines into the system clock domain and finds the start and stop markers. It decodes an address byte that holds pin-strapped select bits and the top three bits of the memory address. It then runs program transfers and read transfers against a synchronous byte RAM port. The data line is driven only through an open-drain enable: a 1 pulls the line low, and a 0 releases it.

After a program transfer that stored at least one byte is closed by a stop, the block enters an internal program interval. During that interval it ignores the bus and does not answer its own address. A host therefore polls by sending the address byte until an acknowledge comes back. Reads are served from an internal pointer. A random read is a short program transfer that carries only the address, followed by a repeated start with the read bit set. The system clock must run at least eight times faster than the bus clock.

Top module: `twowire_mem_slave`

## Requirements
- R1: Before a start has been seen (SDA falling while SCL is high), clocked bus bits get no acknowledge, and SDA stays released.
- R2: The address byte is, from MSB to LSB: bit 7 = 1, bits 6..5 = strap_i[2], strap_i[1], bit 4 = the inverse of strap_i[0], bits 3..1 = memory address bits 10..8, and bit 0 = direction (1 read, 0 program). Any other value gets no acknowledge, and the transfer is ignored until the next start.
- R3: The block pulls SDA low during the ninth SCL pulse after a matching address byte and after every byte written to it.
- R4: In a program transfer, the pointer is formed as {address bits 10..8 from the address byte, next byte}. Each following data byte is written to the pointer with a one-cycle mem_we_o pulse while SCL is low, and the pointer then advances by one.
- R5: Read data is sent MSB first. A 0 bit is sent by asserting sda_oe_o, and sda_oe_o changes only while the synchronised SCL is low.
- R6: A host acknowledge on the ninth pulse of a read byte makes the block send the byte at the next pointer value. The pointer wraps from 0x7FF to 0x000.
- R7: A host non-acknowledge ends the read. SDA stays released for all further clocks until the next start.
- R8: A read that begins straight after a start (current-address read) returns the byte at the pointer, which is one past the last byte written or sent. The high address bits of a read address byte are not used.
- R9: A program transfer that carries only the address byte, followed by a repeated start and a read address byte, returns the data at that address and starts no program interval.
- R10: A stop that ends a program transfer with at least one stored byte starts a program interval of PROG_CYCLES system clocks. During the interval the block gives no acknowledge and writes nothing. Afterwards its address is acknowledged again.
- R11: During and after reset, sda_oe_o and mem_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled |
| strap_i | input | 3 | Pin-strapped select value |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_addr_o | output | ADDR_W | RAM address, read and write |
| mem_wdata_o | output | 8 | RAM write data |
| mem_we_o | output | 1 | RAM write strobe, one cycle |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the address |

## Verification
The hardest situation to reach is a host poll that arrives while the internal program interval is still running. That happens only after a stop that follows stored data, and it must be caught within a window counted in system clocks. The bench sends a write and then starts polling with the address byte straight after the stop. It expects the first poll to get no acknowledge, and a later poll to be answered within a bounded count. The other hard case is the pointer wrap at the top of the array during a sequential read, reached by a random read aimed at the last address.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEV   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4,
    ST_HOLD  = 3'd5
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_d,
  output logic sda_d
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];
endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer #(
  parameter int CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (go_i)              cnt_n = LOAD;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int          ADDR_W      = 11,
  parameter int          PROG_CYCLES = 300,
  parameter int          SYNC_STAGES = 2,
  parameter logic [2:0]  SEL_INV     = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i
);
  import tw_pkg::*;

  localparam int HI_W = ADDR_W - 8;
  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] BIT_ACK  = 4'd9;

  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, prog_go;

  tw_state_e         st_q, st_n;
  logic [3:0]        bit_q, bit_n;
  logic [7:0]        sh_q, sh_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic              rw_q, rw_n, oe_q, oe_n, wrote_q, wrote_n, we;
  logic              dev_match;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_d(scl_d), .sda_d(sda_d)
  );

  tw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go_i(prog_go), .busy_o(busy)
  );

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

  assign dev_match = sh_q[7] & (sh_q[6:4] == (strap_i ^ SEL_INV));

  always_comb begin
    st_n    = st_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    hi_n    = hi_q;
    rw_n    = rw_q;
    oe_n    = oe_q;
    wrote_n = wrote_q;
    we      = 1'b0;
    prog_go = 1'b0;
    if (busy) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_ev) begin
      st_n  = ST_DEV;
      bit_n = '0;
      oe_n  = 1'b0;
    end else if (stop_ev) begin
      st_n    = ST_IDLE;
      oe_n    = 1'b0;
      prog_go = wrote_q;
      wrote_n = 1'b0;
    end else begin
      case (st_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bit_q < BIT_LAST) begin
            sh_n  = {sh_q[6:0], sda_s};
            bit_n = bit_q + 1'b1;
          end else if (scl_fall && bit_q == BIT_LAST) begin
            bit_n = BIT_ACK;
            oe_n  = 1'b1;
            if (st_q == ST_DEV) begin
              if (dev_match) begin
                hi_n = sh_q[HI_W:1];
                rw_n = sh_q[0];
              end else begin
                oe_n = 1'b0;
                st_n = ST_HOLD;
              end
            end else if (st_q == ST_ADDR) begin
              ptr_n = {hi_q, sh_q};
            end else begin
              we      = 1'b1;
              ptr_n   = ptr_q + 1'b1;
              wrote_n = 1'b1;
            end
          end else if (scl_fall && bit_q == BIT_ACK) begin
            oe_n  = 1'b0;
            bit_n = '0;
            if (st_q == ST_DEV && rw_q) begin
              st_n = ST_RDATA;
              sh_n = mem_rdata_i;
              oe_n = ~mem_rdata_i[7];
            end else if (st_q == ST_DEV) begin
              st_n = ST_ADDR;
            end else begin
              st_n = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise && bit_q < BIT_LAST) begin
            bit_n = bit_q + 1'b1;
          end else if (scl_rise && bit_q == BIT_LAST) begin
            if (!sda_s) bit_n = BIT_ACK;
            else        st_n  = ST_HOLD;
          end else if (scl_fall && bit_q == BIT_LAST) begin
            oe_n  = 1'b0;
            ptr_n = ptr_q + 1'b1;
          end else if (scl_fall && bit_q == BIT_ACK) begin
            sh_n  = mem_rdata_i;
            oe_n  = ~mem_rdata_i[7];
            bit_n = '0;
          end else if (scl_fall && bit_q != '0) begin
            sh_n = {sh_q[6:0], 1'b0};
            oe_n = ~sh_q[6];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      hi_q    <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      wrote_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      hi_q    <= hi_n;
      rw_q    <= rw_n;
      oe_q    <= oe_n;
      wrote_q <= wrote_n;
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = sh_q;
  assign mem_we_o    = we;
endmodule

// File: rtl/tw_slave_checker.sv
module tw_slave_checker (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_s,
  input logic            sda_oe_o,
  input logic            mem_we_o,
  input logic            busy,
  input logic            stop_ev,
  input tw_pkg::tw_state_e st
);
  import tw_pkg::*;

  assert_oe_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe_o);

  assert_write_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (!scl_s && st == ST_WDATA));

  assert_busy_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sda_oe_o && !mem_we_o));

  assert_busy_from_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));
endmodule

bind twowire_mem_slave tw_slave_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .mem_we_o(mem_we_o), .busy(busy), .stop_ev(stop_ev), .st(st_q)
);

// File: tb/test_twowire_mem_slave.sv
module test_twowire_mem_slave;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n, scl_m, sda_m;
  logic [2:0] strap;
  logic sda_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] ram [DEPTH];
  logic [7:0] expm [DEPTH];
  wire line = sda_m & ~sda_oe;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  twowire_mem_slave #(.ADDR_W(AW), .PROG_CYCLES(PROG)) i_twowire_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .strap_i(strap),
    .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; q(); scl_m = 1'b1; q(); s = line; q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] v);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      v = {v[6:0], s};
    end
    clk_bit(~host_ack, s);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] st, input logic [2:0] hi, input logic rw);
    return {1'b1, st[2], st[1], ~st[0], hi, rw};
  endfunction

  task automatic wait_ready(output int polls);
    logic a;
    polls = 0;
    for (int k = 0; k < 40; k++) begin
      bus_start();
      send_byte(dev(strap, 3'd0, 1'b0), a);
      bus_stop();
      polls++;
      if (a) break;
    end
  endtask

  task automatic wr(input int addr, input int n, input int seed);
    logic a;
    logic [10:0] ad;
    ad = addr[10:0];
    bus_start();
    send_byte(dev(strap, ad[10:8], 1'b0), a); chk("R3 dev ack", a, 1);
    send_byte(ad[7:0], a);                    chk("R3 addr ack", a, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'(seed + 29 * k);
      send_byte(d, a); chk("R3 data ack", a, 1);
      expm[(addr + k) % DEPTH] = d;
    end
    bus_stop();
  endtask

  task automatic rd(input int addr, input int n);
    logic a;
    logic [7:0] v;
    logic [10:0] ad;
    ad = addr[10:0];
    bus_start();
    send_byte(dev(strap, ad[10:8], 1'b0), a); chk("R9 dummy dev ack", a, 1);
    send_byte(ad[7:0], a);                    chk("R9 dummy addr ack", a, 1);
    bus_start();
    send_byte(dev(strap, 3'd0, 1'b1), a);     chk("R9 read dev ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, v);
      chk("R5 R6 read data", v, expm[(addr + k) % DEPTH]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, s;
    logic [7:0] v;
    int polls, lows;
    for (int i = 0; i < DEPTH; i++) begin
      ram[i]  = 8'(i * 7 + (i >> 5));
      expm[i] = 8'(i * 7 + (i >> 5));
    end
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 3'b101;
    repeat (5) @(negedge clk);
    chk("R11 oe in reset", sda_oe, 0);
    chk("R11 we in reset", mem_we, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 oe after reset", sda_oe, 0);

    // R1: bits clocked with no start
    scl_m = 1'b0; q();
    send_byte(dev(strap, 3'd0, 1'b0), a);
    chk("R1 no ack before start", a, 0);
    bus_stop();

    // R2: sweep of strap value against select field
    for (int sv = 0; sv < 8; sv++) begin
      strap = 3'(sv);
      for (int d = 0; d < 8; d++) begin
        logic [2:0] dd;
        dd = 3'(d);
        bus_start();
        send_byte({1'b1, dd, 3'd0, 1'b0}, a);
        chk("R2 select compare", a, (dd == {strap[2], strap[1], ~strap[0]}) ? 1 : 0);
        bus_stop();
      end
    end
    strap = 3'b011;
    bus_start();
    send_byte({1'b0, strap[2], strap[1], ~strap[0], 3'd0, 1'b0}, a);
    chk("R2 type bit zero", a, 0);
    bus_stop();

    // R4 R10: write then poll during program interval
    wr(16'h0123, 4, 8'h5a);
    wait_ready(polls);
    chk("R10 first poll refused", polls > 1, 1);
    chk("R10 ready within bound", polls < 6, 1);
    rd(16'h0123, 4);

    // R4 R9: one write and readback per high address value
    for (int h = 0; h < 8; h++) begin
      wr(h * 256 + h * 37, 2, h * 11 + 1);
      wait_ready(polls);
      chk("R4 ready after write", polls > 1, 1);
      rd(h * 256 + h * 37, 2);
    end

    // R9: address-only transfer must not start a program interval
    bus_start();
    send_byte(dev(strap, 3'd2, 1'b0), a);
    send_byte(8'h10, a);
    bus_stop();
    wait_ready(polls);
    chk("R9 no interval after dummy", polls, 1);

    // R6: wrap at top during sequential read
    rd(DEPTH - 2, 4);

    // R8: current-address read continues after last byte sent (addr 2)
    bus_start();
    send_byte(dev(strap, 3'd7, 1'b1), a);
    chk("R8 read ack", a, 1);
    recv_byte(1'b1, v);
    chk("R8 current address byte", v, expm[2]);
    recv_byte(1'b0, v);
    chk("R8 next byte", v, expm[3]);

    // R7: after host nack no drive
    lows = 0;
    for (int k = 0; k < 9; k++) begin
      clk_bit(1'b1, s);
      if (!s) lows++;
    end
    chk("R7 released after nack", lows, 0);
    bus_stop();

    // R10: data sent during interval is not stored
    wr(16'h0040, 1, 8'h33);
    bus_start();
    send_byte(dev(strap, 3'd0, 1'b0), a);
    chk("R10 no ack while busy", a, 0);
    send_byte(8'h40, a);
    send_byte(8'hee, a);
    bus_stop();
    wait_ready(polls);
    rd(16'h0040, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule